// File: doc/BRIEF.md
# I2C Bus State Monitor

This block watches the two wires of an I2C bus from inside a master controller. It brings the raw SDA and SCL levels into the system clock domain and finds start, repeated start and stop conditions by edge detection. From these it keeps a two-bit view of who holds the bus: nobody known yet, the bus is free, this master holds it, or another master holds it. The line is expected to be oversampled at least four times per SCL period.

It also checks framing. A start or stop seen while a transfer is open is legal only on a byte boundary, which is after a whole number of data bytes, each eight data bits plus an acknowledge bit. Anything else, including a stop that follows a start with no data at all, is reported as a one-cycle bus-error pulse. The byte engine around it supplies whether the current start was its own and pulses arbitration loss. Software may only force the view to idle.

Top module: `i2c_bus_monitor`

## Requirements
- R1: The state encoding is 0 unknown, 1 idle, 2 owner, 3 busy. After reset `bus_state` is 0 and `bus_err` is 0.
- R2: While `master_en` is 0, `bus_state` is 0 (unknown) one cycle later. After re-enabling, it stays 0 until a bus event or a force write.
- R3: A stop is SDA rising while SCL is high. A stop seen while enabled sets `bus_state` to 1 (idle). This takes three clock edges after the line change.
- R4: A start is SDA falling while SCL is high. A legal start with `own_start` high sets `bus_state` to 2 (owner).
- R5: A legal start with `own_start` low sets `bus_state` to 3 (busy).
- R6: A cycle with `force_wr` high and `force_val` equal to 1 sets `bus_state` to 1 while enabled. Any other `force_val` leaves the state unchanged. A force write while disabled has no effect.
- R7: An `arb_lost` pulse in state 2 moves the state to 3. In any other state it leaves the state unchanged.
- R8: A stop that follows a start with no data bit between them raises `bus_err` for exactly one cycle. This covers the case with no SCL edge in between and the case with only the single SCL low-high cycle that sets up the stop.
- R9: Inside an open transfer, the number of data bits is the number of SCL falling edges since the last start, minus one. A start or stop there is legal only when that count is a positive multiple of 9. Otherwise `bus_err` pulses.
- R10: A repeated start that raises `bus_err` sets the state to 3 (busy), even when `own_start` is high.
- R11: A start or stop seen with no transfer open never raises `bus_err`. A transfer is open from a start until the next stop or disable.
- R12: While `master_en` is 0, `bus_err` stays 0 and any open transfer is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA level from the pad |
| scl_in | input | 1 | Raw SCL level from the pad |
| master_en | input | 1 | Master enable; low forces state unknown |
| own_start | input | 1 | High when the current start was issued by this master |
| arb_lost | input | 1 | One-cycle arbitration-lost pulse |
| force_wr | input | 1 | Software write strobe to the state field |
| force_val | input | 2 | Value written by software; only 1 takes effect |
| bus_state | output | 2 | Current bus state (0 unknown, 1 idle, 2 owner, 3 busy) |
| bus_err | output | 1 | One-cycle bus-error pulse |

## Verification
A line change reaches `bus_state` and `bus_err` on the third rising edge after it is driven: two synchronizer stages and then the state register. A control input such as `force_wr`, `arb_lost` or `master_en` acts on the first edge. The bench drives every bus phase for at least two cycles and the final phase of each condition for four. It samples on the falling edge after the phase ends, so each result has settled by the time it is read. Error pulses are counted on every falling edge and compared as a count per condition, so a missing pulse or an extra pulse both show up.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef enum logic [1:0] {
        BS_UNKNOWN = 2'd0,
        BS_IDLE    = 2'd1,
        BS_OWNER   = 2'd2,
        BS_BUSY    = 2'd3
    } bus_state_e;

    // synchronized line pair
    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    // conditions found on the lines in one sample step
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_fall;
    } line_evt_t;

    function automatic line_evt_t decode_lines(line_pair_t prev, line_pair_t cur);
        line_evt_t e;
        e.start    = prev.scl & cur.scl & prev.sda & ~cur.sda;
        e.stop     = prev.scl & cur.scl & ~prev.sda & cur.sda;
        e.scl_fall = prev.scl & ~cur.scl;
        return e;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t lines,
    output line_evt_t  evt
);
    line_pair_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lines;
    end

    assign evt = decode_lines(prev_q, lines);
endmodule

// File: rtl/i2cmon_frame_check.sv
module i2cmon_frame_check
    import i2cmon_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  line_evt_t evt,
    output logic      viol,
    output logic      bus_err
);
    // falls counted: first fall closes the start, then one per data/ack bit
    localparam int                LEGAL_FALLS = BYTE_BITS + 2;
    localparam int                CNT_W       = $clog2(LEGAL_FALLS + 1);
    localparam logic [CNT_W-1:0]  CNT_LEGAL   = CNT_W'(LEGAL_FALLS);
    localparam logic [CNT_W-1:0]  CNT_WRAP    = CNT_W'(2);

    logic             frame_open_q;
    logic [CNT_W-1:0] fall_cnt_q;

    assign viol = en && frame_open_q && (evt.start || evt.stop) && (fall_cnt_q != CNT_LEGAL);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            frame_open_q <= 1'b0;
            fall_cnt_q   <= '0;
            bus_err      <= 1'b0;
        end else begin
            bus_err <= viol;
            if (evt.start) begin
                frame_open_q <= 1'b1;
                fall_cnt_q   <= '0;
            end else if (evt.stop) begin
                frame_open_q <= 1'b0;
                fall_cnt_q   <= '0;
            end else if (evt.scl_fall && frame_open_q) begin
                fall_cnt_q <= (fall_cnt_q == CNT_LEGAL) ? CNT_WRAP : fall_cnt_q + 1'b1;
            end
        end
    end

    AST_ERR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(frame_open_q)); // R11
    AST_NO_ERR_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en |=> !bus_err); // R12
endmodule

// File: rtl/i2cmon_state_fsm.sv
module i2cmon_state_fsm
    import i2cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  line_evt_t  evt,
    input  logic       viol,
    input  logic       own_start,
    input  logic       arb_lost,
    input  logic       force_wr,
    input  logic [1:0] force_val,
    output bus_state_e state
);
    bus_state_e nxt;

    always_comb begin
        nxt = state;
        if (!en)
            nxt = BS_UNKNOWN;
        else if (evt.stop)
            nxt = BS_IDLE;
        else if (evt.start)
            nxt = (viol || !own_start) ? BS_BUSY : BS_OWNER;
        else if (arb_lost && state == BS_OWNER)
            nxt = BS_BUSY;
        else if (force_wr && force_val == BS_IDLE)
            nxt = BS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= BS_UNKNOWN;
        else     state <= nxt;
    end

    AST_DISABLED_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == BS_UNKNOWN); // R2
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (en && evt.stop) |=> state == BS_IDLE); // R3
    AST_OWNER_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(state == BS_OWNER) |-> $past(evt.start && own_start && !viol)); // R4
    AST_ARB_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (en && arb_lost && state == BS_OWNER && !evt.start && !evt.stop) |=> state == BS_BUSY); // R7
    AST_VIOL_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (en && evt.start && viol) |=> state == BS_BUSY); // R10
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_BITS   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic       master_en,
    input  logic       own_start,
    input  logic       arb_lost,
    input  logic       force_wr,
    input  logic [1:0] force_val,
    output logic [1:0] bus_state,
    output logic       bus_err
);
    localparam int LINE_W = $bits(line_pair_t);

    line_pair_t raw_lines;
    line_pair_t sync_lines;
    line_evt_t  evt;
    logic       viol;
    bus_state_e state;

    assign raw_lines.scl = scl_in;
    assign raw_lines.sda = sda_in;

    i2cmon_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (LINE_W),
        .RST_VAL ('1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    i2cmon_cond_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .lines (sync_lines),
        .evt   (evt)
    );

    i2cmon_frame_check #(
        .BYTE_BITS (BYTE_BITS)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .en      (master_en),
        .evt     (evt),
        .viol    (viol),
        .bus_err (bus_err)
    );

    i2cmon_state_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (master_en),
        .evt       (evt),
        .viol      (viol),
        .own_start (own_start),
        .arb_lost  (arb_lost),
        .force_wr  (force_wr),
        .force_val (force_val),
        .state     (state)
    );

    assign bus_state = state;

    AST_ERR_STATE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_state == BS_IDLE || bus_state == BS_BUSY)); // R8
endmodule

// File: tb/i2c_bus_monitor_bench.sv
module i2c_bus_monitor_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sda = 1'b1;
    logic       scl = 1'b1;
    logic       master_en = 1'b0;
    logic       own_start = 1'b0;
    logic       arb_lost = 1'b0;
    logic       force_wr = 1'b0;
    logic [1:0] force_val = 2'd0;
    logic [1:0] bus_state;
    logic       bus_err;

    int n_chk  = 0;
    int n_fail = 0;
    int err_seen = 0;
    int err_mark = 0;
    bit done = 0;

    // bench model
    logic [1:0] exp_state;
    bit         in_frame;

    always #5 clk = ~clk;

    i2c_bus_monitor u_i2c_bus_monitor (
        .clk       (clk),
        .rst       (rst),
        .sda_in    (sda),
        .scl_in    (scl),
        .master_en (master_en),
        .own_start (own_start),
        .arb_lost  (arb_lost),
        .force_wr  (force_wr),
        .force_val (force_val),
        .bus_state (bus_state),
        .bus_err   (bus_err)
    );

    always @(negedge clk) if (!rst && bus_err) err_seen++;

    function automatic bit frame_ok(int bits, bit direct);
        return !direct && bits > 0 && (bits % 9) == 0;
    endfunction

    function automatic logic [1:0] state_after_start(bit open, bit ok, bit own);
        if (open && !ok) return 2'd3;
        return own ? 2'd2 : 2'd3;
    endfunction

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_state(logic [1:0] exp, string tag);
        n_chk++;
        if (bus_state !== exp) begin
            n_fail++;
            $display("FAIL %s: bus_state=%0d expected %0d", tag, bus_state, exp);
        end
    endtask

    task automatic chk_err(int exp, string tag);
        int d;
        d = err_seen - err_mark;
        err_mark = err_seen;
        n_chk++;
        if (d != exp) begin
            n_fail++;
            $display("FAIL %s: bus_err pulses=%0d expected %0d", tag, d, exp);
        end
    endtask

    // bus phases; each leaves SCL high
    task automatic do_start(bit own);
        own_start = own;
        sda = 1'b0; hold(4);
    endtask

    task automatic do_bit(bit b);
        scl = 1'b0; hold(2);
        sda = b;    hold(2);
        scl = 1'b1; hold(4);
    endtask

    task automatic do_bits(int n);
        for (int i = 0; i < n; i++) do_bit(1'($urandom % 2));
    endtask

    task automatic do_stop();
        scl = 1'b0; hold(2);
        sda = 1'b0; hold(2);
        scl = 1'b1; hold(4);
        sda = 1'b1; hold(4);
    endtask

    task automatic do_stop_direct();
        sda = 1'b1; hold(4);
    endtask

    task automatic do_rstart(bit own);
        scl = 1'b0; hold(2);
        sda = 1'b1; hold(2);
        scl = 1'b1; hold(4);
        own_start = own;
        sda = 1'b0; hold(4);
    endtask

    task automatic pulse_force(logic [1:0] v);
        force_val = v; force_wr = 1'b1; hold(1);
        force_wr = 1'b0; hold(1);
    endtask

    task automatic pulse_arb();
        arb_lost = 1'b1; hold(1);
        arb_lost = 1'b0; hold(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c2b_5a17));
        hold(4);
        rst = 1'b0;
        hold(1);
        chk_state(2'd0, "R1 reset state");
        chk_err(0, "R1 reset error output");

        master_en = 1'b1; hold(5);
        chk_state(2'd0, "R2 unknown after enable");

        pulse_force(2'd2);
        chk_state(2'd0, "R6 force value 2 ignored");
        pulse_force(2'd3);
        chk_state(2'd0, "R6 force value 3 ignored");
        pulse_force(2'd1);
        chk_state(2'd1, "R6 force value 1 to idle");

        do_stop();
        chk_state(2'd1, "R3 stop keeps idle");
        chk_err(0, "R11 stop with no transfer open");

        do_start(1'b1);
        chk_state(2'd2, "R4 own start to owner");
        chk_err(0, "R11 first start no error");
        do_bits(9);
        do_stop();
        chk_state(2'd1, "R3 stop to idle");
        chk_err(0, "R9 stop after 9 bits legal");

        do_start(1'b0);
        chk_state(2'd3, "R5 foreign start to busy");
        do_stop_direct();
        chk_state(2'd1, "R3 stop after bad frame idle");
        chk_err(1, "R8 start then direct stop");

        do_start(1'b1);
        do_stop();
        chk_err(1, "R8 start then stop, zero bits");

        do_start(1'b1);
        chk_state(2'd2, "R4 own start again");
        do_bits(3);
        do_rstart(1'b1);
        chk_state(2'd3, "R10 bad repeated start to busy");
        chk_err(1, "R9 repeated start mid byte");
        do_bits(18);
        do_stop();
        chk_state(2'd1, "R3 stop after 18 bits");
        chk_err(0, "R9 stop after 18 bits legal");

        do_start(1'b1);
        do_bits(2);
        pulse_arb();
        chk_state(2'd3, "R7 arbitration lost in owner");
        do_bits(7);
        do_stop();
        chk_err(0, "R9 arb does not affect framing");
        pulse_arb();
        chk_state(2'd1, "R7 arbitration lost ignored in idle");

        do_start(1'b1);
        do_bits(4);
        master_en = 1'b0; hold(2);
        chk_state(2'd0, "R2 disable to unknown");
        do_bits(2);
        do_stop_direct();
        chk_err(0, "R12 no error while disabled");
        chk_state(2'd0, "R2 stays unknown while disabled");
        pulse_force(2'd1);
        chk_state(2'd0, "R6 force ignored while disabled");
        master_en = 1'b1; hold(3);
        chk_state(2'd0, "R2 unknown after re-enable");
        do_stop();
        chk_err(0, "R12 transfer closed by disable");
        chk_state(2'd1, "R3 stop after re-enable");

        exp_state = 2'd1;
        in_frame  = 0;
        for (int it = 0; it < 60; it++) begin
            int  nb;
            bit  own;
            bit  ok;
            bit  direct;
            if (!in_frame) begin
                own = 1'($urandom % 2);
                do_start(own);
                exp_state = state_after_start(0, 1, own);
                in_frame = 1;
                chk_state(exp_state, "R4 R5 random start");
            end
            nb = ($urandom % 3 == 0) ? 9 * (1 + int'($urandom % 2)) : int'($urandom % 21);
            do_bits(nb);
            if ($urandom % 5 == 0) begin
                pulse_arb();
                if (exp_state == 2'd2) exp_state = 2'd3;
                chk_state(exp_state, "R7 random arbitration lost");
            end
            direct = (nb == 0) && ($urandom % 2 == 1);
            ok = frame_ok(nb, direct);
            if (!direct && ($urandom % 3 == 0)) begin
                own = 1'($urandom % 2);
                do_rstart(own);
                exp_state = state_after_start(1, ok, own);
                chk_state(exp_state, "R10 random repeated start");
            end else begin
                if (direct) do_stop_direct();
                else        do_stop();
                exp_state = 2'd1;
                in_frame = 0;
                chk_state(exp_state, "R3 random stop");
            end
            chk_err(ok ? 0 : 1, "R9 random framing");
        end
        if (in_frame) begin
            do_bits(9);
            do_stop();
            chk_state(2'd1, "R3 final stop");
            chk_err(0, "R9 final stop legal");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule